// File: doc/BRIEF.md
# Serial Configuration Register Port

This block receives short write-only frames over three wires (a select, a bit clock and a data line) and keeps four 6-bit configuration registers for a low-frequency wake-up receiver. The three wires come from outside the chip and are therefore not tied to the system clock. They pass through a synchronizer, and their edges are found in the system clock domain.

A frame is eight bits, sent least significant bit first. The first two bits pick one of the four registers and the remaining six bits are the new contents. Nothing is written while the select line is high. The write takes effect when the select line falls, and only if exactly eight bits were clocked in since it rose. The registers leave reset holding non-zero defaults. Their fields are driven out as decoded control signals, including the antenna-to-channel mapping that follows from the rotator field. There is no read path.

Top module: `cfg3w_port`

## Requirements
- R1: After reset the four register images are: power 6'h0F (three channel enables and the regulator enable set, rotator field 00), channel 6'h00, test 6'h10 (only the step-select bit set), correlator 6'h18 (half-bit mode field 2'b10 and the detector time-constant bit set).
- R2: While `sel_in` is high, each rising edge of `sclk_in` samples `sdat_in`. The first bit sampled is address bit 0, the second is address bit 1, and bits three to eight are data bits 0 to 5.
- R3: Address 0 selects the power register, 1 the channel register, 2 the test register and 3 the correlator register.
- R4: A complete frame changes no output before `sel_in` falls. The new value appears within a few system clocks after the fall, and registers that were not addressed keep their value.
- R5: A frame with fewer than eight bits clocked before `sel_in` falls changes no register.
- R6: A frame with more than eight bits clocked before `sel_in` falls changes no register.
- R7: Rising edges of `sclk_in` while `sel_in` is low change no register.
- R8: Rotator field values 0, 1 and 2 map channel k to antenna source (k+value) mod 3. Each source is a 2-bit index, packed as channel 0 in bits 1:0 of `rot_src`. Value 3 asserts `rot_short` and gives each channel the source index equal to its own number. `rot_short` is low for the other values.
- R9: Field positions. Power register: bits 2:0 channel enables, bit 3 regulator, bits 5:4 rotator. Channel register: bits 1:0 strength-channel select, bits 3:2 strength-output mode, bit 4 attenuator, bit 5 wake clear. Test register: bit 0 enable, bits 2:1 select, bit 3 auxiliary, bit 4 step select, bit 5 wake generator. Correlator register: bit 0 off, bit 1 double pattern, bits 3:2 half-bit mode, bit 4 time constant, bit 5 auxiliary.
- R10: Each rising edge of `sel_in` starts a fresh bit count, so a discarded short frame does not affect the frame that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_in | input | 1 | Frame select, high during a frame |
| sclk_in | input | 1 | Serial bit clock, data sampled on rising edge |
| sdat_in | input | 1 | Serial data, least significant bit first |
| ch_en | output | 3 | Receiver channel enables |
| reg_en | output | 1 | Regulator enable |
| rot_mode | output | 2 | Rotator field |
| rot_src | output | 6 | Antenna source index per channel, channel 0 lowest |
| rot_short | output | 1 | All inputs shorted |
| rssi_sel | output | 2 | Strength-channel select |
| rssi_mode | output | 2 | Strength-output mode |
| atten_on | output | 1 | Input attenuator on |
| wake_clr | output | 1 | Wake clear |
| test_en | output | 1 | Test mode enable |
| test_sel | output | 2 | Test mode select |
| test_aux | output | 1 | Test register auxiliary bit |
| step_hi | output | 1 | High step select |
| wakegen_en | output | 1 | Periodic wake generator enable |
| corr_off | output | 1 | Correlator off |
| corr_double | output | 1 | Double pattern mode |
| corr_halfbit | output | 2 | Half-bit detection mode |
| corr_tc | output | 1 | Detector time constant select |
| corr_aux | output | 1 | Correlator register auxiliary bit |

## Verification
The assertions assume a few things about the serial inputs. `sclk_in` stays high and stays low for at least two system clocks each. `sdat_in` is steady around every rising `sclk_in`. `sel_in`, once it falls, stays low for several system clocks. The bench drives the bit clock with twelve system clocks per period and changes data only while the clock is low. It raises the select line six clocks before the first bit and holds it low for ten clocks after each frame, so every property sees inputs inside those limits.

// File: rtl/cfg3w_pkg.sv
// Shared constants for the three-wire configuration port.
// Assumes an 8-bit frame made of a 2-bit address and a 6-bit payload.
package cfg3w_pkg;
    localparam int ADDR_W  = 2;
    localparam int DATA_W  = 6;
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int NREGS   = 1 << ADDR_W;
    localparam int NCH     = 3;
    localparam int SRC_W   = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_PWR  = 2'd0,
        REG_CHAN = 2'd1,
        REG_TEST = 2'd2,
        REG_CORR = 2'd3
    } reg_sel_e;

    localparam logic [1:0] ROT_SHORT = 2'b11;

    localparam logic [NREGS-1:0][DATA_W-1:0] RESET_IMAGE = {
        6'h18,   // correlator
        6'h10,   // test
        6'h00,   // channel
        6'h0F    // power
    };
endpackage

// File: rtl/cfg3w_sync.sv
// Multi-stage synchronizer for asynchronous serial pins.
// Assumes inputs change slowly relative to clk; resets to zero (idle low).
module cfg3w_sync #(
    parameter int W     = 3,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [DEPTH-1:0][W-1:0] stage;

    // Shift the pin values through DEPTH flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else begin
            stage[0] <= din;
            for (int k = 1; k < DEPTH; k++) begin
                stage[k] <= stage[k-1];
            end
        end
    end

    assign dout = stage[DEPTH-1];
endmodule

// File: rtl/cfg3w_frame_rx.sv
// Frame receiver: counts rising bit-clock edges while select is high,
// shifts data in LSB first and issues a one-cycle write on select fall
// when exactly FRAME_W bits were captured.
// Assumes synchronized inputs and bit-clock phases of two clocks or more.
module cfg3w_frame_rx
    import cfg3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sck,
    input  logic              sd,
    output logic              wr_vld,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVF  = CNT_W'(FRAME_W + 1);

    logic               cs_d, sck_d;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] shreg;
    logic               cs_rise, cs_fall, sck_rise;

    assign cs_rise  = cs & ~cs_d;
    assign cs_fall  = ~cs & cs_d;
    assign sck_rise = sck & ~sck_d;

    // Edge history, bit capture, counting and commit pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d    <= 1'b0;
            sck_d   <= 1'b0;
            cnt     <= '0;
            shreg   <= '0;
            wr_vld  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            cs_d   <= cs;
            sck_d  <= sck;
            wr_vld <= 1'b0;
            if (cs_rise) begin
                cnt <= '0;
            end else if (cs && sck_rise) begin
                shreg <= {sd, shreg[FRAME_W-1:1]};
                if (cnt != CNT_OVF) cnt <= cnt + 1'b1;
            end
            if (cs_fall && cnt == CNT_FULL) begin
                wr_vld  <= 1'b1;
                wr_addr <= shreg[ADDR_W-1:0];
                wr_data <= shreg[FRAME_W-1:ADDR_W];
            end
        end
    end

    // R6
    // cnt_bound_chk
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_OVF);

    // R4
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |=> !wr_vld);

    // R4
    wr_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |-> !cs);

    // R7
    sck_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> $stable(cnt));
endmodule

// File: rtl/cfg3w_regfile.sv
// Four configuration registers with per-register reset values.
// Assumes a single-cycle write strobe from the frame receiver.
module cfg3w_regfile
    import cfg3w_pkg::*;
#(
    parameter logic [NREGS-1:0][DATA_W-1:0] RST_VAL = RESET_IMAGE
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_vld,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NREGS-1:0][DATA_W-1:0]  regs
);
    logic [NREGS-1:0] we;

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        assign we[r] = wr_vld && (wr_addr == ADDR_W'(r));

        // Hold or load one register
        always_ff @(posedge clk) begin
            if (!rst_n)     regs[r] <= RST_VAL[r];
            else if (we[r]) regs[r] <= wr_data;
        end
    end

    // R3
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_vld |=> $stable(regs));
endmodule

// File: rtl/cfg3w_rot_map.sv
// Rotator decode: cyclic antenna-to-channel mapping, or all-short.
// Assumes NCH fits in 2**IW source codes.
module cfg3w_rot_map
    import cfg3w_pkg::*;
#(
    parameter int N  = NCH,
    parameter int IW = SRC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    output logic [N-1:0][IW-1:0] src,
    output logic                 short_o
);
    logic [(1<<IW)-1:0] mask;

    assign short_o = (mode == ROT_SHORT);

    for (genvar ch = 0; ch < N; ch++) begin : g_ch
        // Source index for one channel
        always_comb begin
            int sum;
            sum = ch + int'(mode);
            if (short_o)      src[ch] = IW'(ch);
            else if (sum >= N) src[ch] = IW'(sum - N);
            else              src[ch] = IW'(sum);
        end
    end

    // Collect which sources are in use
    always_comb begin
        mask = '0;
        for (int ch = 0; ch < N; ch++) mask[src[ch]] = 1'b1;
    end

    // R8
    rot_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mask) == N);

    // R8
    rot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask >> N) == '0);
endmodule

// File: rtl/cfg3w_port.sv
// Top of the three-wire configuration port: synchronizer, frame
// receiver, register file and field decode.
// Assumes system clock at least four times the serial bit clock.
module cfg3w_port
    import cfg3w_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_in,
    input  logic       sclk_in,
    input  logic       sdat_in,
    output logic [2:0] ch_en,
    output logic       reg_en,
    output logic [1:0] rot_mode,
    output logic [5:0] rot_src,
    output logic       rot_short,
    output logic [1:0] rssi_sel,
    output logic [1:0] rssi_mode,
    output logic       atten_on,
    output logic       wake_clr,
    output logic       test_en,
    output logic [1:0] test_sel,
    output logic       test_aux,
    output logic       step_hi,
    output logic       wakegen_en,
    output logic       corr_off,
    output logic       corr_double,
    output logic [1:0] corr_halfbit,
    output logic       corr_tc,
    output logic       corr_aux
);
    logic [2:0]                       pins_s;
    logic                             wr_vld;
    logic [ADDR_W-1:0]                wr_addr;
    logic [DATA_W-1:0]                wr_data;
    logic [NREGS-1:0][DATA_W-1:0]     regs;
    logic [NCH-1:0][SRC_W-1:0]        src;

    cfg3w_sync #(.W(3), .DEPTH(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sel_in, sclk_in, sdat_in}),
        .dout (pins_s)
    );

    cfg3w_frame_rx u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs     (pins_s[2]),
        .sck    (pins_s[1]),
        .sd     (pins_s[0]),
        .wr_vld (wr_vld),
        .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    cfg3w_regfile u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_vld (wr_vld),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .regs   (regs)
    );

    cfg3w_rot_map u_rot (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (regs[REG_PWR][5:4]),
        .src    (src),
        .short_o(rot_short)
    );

    assign rot_src = src;

    // Field decode of the four registers
    assign ch_en        = regs[REG_PWR][2:0];
    assign reg_en       = regs[REG_PWR][3];
    assign rot_mode     = regs[REG_PWR][5:4];
    assign rssi_sel     = regs[REG_CHAN][1:0];
    assign rssi_mode    = regs[REG_CHAN][3:2];
    assign atten_on     = regs[REG_CHAN][4];
    assign wake_clr     = regs[REG_CHAN][5];
    assign test_en      = regs[REG_TEST][0];
    assign test_sel     = regs[REG_TEST][2:1];
    assign test_aux     = regs[REG_TEST][3];
    assign step_hi      = regs[REG_TEST][4];
    assign wakegen_en   = regs[REG_TEST][5];
    assign corr_off     = regs[REG_CORR][0];
    assign corr_double  = regs[REG_CORR][1];
    assign corr_halfbit = regs[REG_CORR][3:2];
    assign corr_tc      = regs[REG_CORR][4];
    assign corr_aux     = regs[REG_CORR][5];
endmodule

// File: tb/cfg3w_port_test.sv
module cfg3w_port_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_in = 1'b0, sclk_in = 1'b0, sdat_in = 1'b0;
    logic [2:0] ch_en;
    logic reg_en, rot_short, atten_on, wake_clr, test_en, test_aux;
    logic step_hi, wakegen_en, corr_off, corr_double, corr_tc, corr_aux;
    logic [1:0] rot_mode, rssi_sel, rssi_mode, test_sel, corr_halfbit;
    logic [5:0] rot_src;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [5:0] model [4];

    always #4 clk = ~clk;

    cfg3w_port uut (.*);

    // frame = {data[5:0], addr[1:0]}, bit 0 sent first
    localparam logic [7:0] VEC [8] = '{
        {6'h2A, 2'd0}, {6'h15, 2'd1}, {6'h3F, 2'd2}, {6'h01, 2'd3},
        {6'h30, 2'd0}, {6'h22, 2'd1}, {6'h09, 2'd2}, {6'h3E, 2'd3}
    };

    function automatic logic [23:0] image();
        return {corr_aux, corr_tc, corr_halfbit, corr_double, corr_off,
                wakegen_en, step_hi, test_aux, test_sel, test_en,
                wake_clr, atten_on, rssi_mode, rssi_sel,
                rot_mode, reg_en, ch_en};
    endfunction

    function automatic logic [23:0] model_img();
        return {model[3], model[2], model[1], model[0]};
    endfunction

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int nbits, input logic [15:0] bits, input bit drop);
        sel_in = 1'b1;
        wt(6);
        for (int i = 0; i < nbits; i++) begin
            sdat_in = bits[i];
            wt(3);
            sclk_in = 1'b1;
            wt(6);
            sclk_in = 1'b0;
            wt(3);
        end
        if (drop) begin
            sel_in = 1'b0;
            wt(10);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(3);
        model[0] = 6'h0F; model[1] = 6'h00; model[2] = 6'h10; model[3] = 6'h18;
        // R1 reset image, R9 field positions
        chk("R1", image(), 24'h61_00_0F ^ 24'h000000 | {6'h18, 6'h10, 6'h00, 6'h0F});
        chk("R1 power", {18'd0, ch_en, reg_en, rot_mode}, {18'd0, 3'b111, 1'b1, 2'b00});
        chk("R1 corr", {20'd0, corr_halfbit, corr_tc, step_hi}, {20'd0, 2'b10, 1'b1, 1'b1});

        // R2 R3 R9 vector table
        foreach (VEC[v]) begin
            send(8, {8'd0, VEC[v]}, 1'b1);
            model[VEC[v][1:0]] = VEC[v][7:2];
            chk("R2/R3/R9 table", image(), model_img());
        end

        // R4: no change while select is still high after 8 bits
        send(8, {8'd0, 6'h05, 2'd1}, 1'b0);
        wt(10);
        chk("R4 before fall", image(), model_img());
        sel_in = 1'b0;
        wt(10);
        model[1] = 6'h05;
        chk("R4 after fall", image(), model_img());

        // R5: short frame discarded
        send(5, {8'd0, 6'h3F, 2'd2}, 1'b1);
        chk("R5", image(), model_img());

        // R6: long frame discarded
        send(9, {7'd0, 1'b1, 6'h11, 2'd0}, 1'b1);
        chk("R6", image(), model_img());

        // R7: bit clocks with select low
        for (int i = 0; i < 8; i++) begin
            sdat_in = ~sdat_in;
            wt(3); sclk_in = 1'b1; wt(6); sclk_in = 1'b0; wt(3);
        end
        wt(10);
        chk("R7", image(), model_img());

        // R10: short frame then full frame
        send(3, 16'h0007, 1'b1);
        send(8, {8'd0, 6'h2C, 2'd3}, 1'b1);
        model[3] = 6'h2C;
        chk("R10", image(), model_img());

        // R8 rotator mapping
        for (int m = 0; m < 4; m++) begin
            logic [5:0] exp_src;
            send(8, {8'd0, 2'(m), 4'hF, 2'd0}, 1'b1);
            for (int c = 0; c < 3; c++)
                exp_src[2*c +: 2] = (m == 3) ? 2'(c) : 2'((c + m) % 3);
            chk("R8 map", {17'd0, rot_short, rot_src}, {17'd0, (m == 3), exp_src});
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule